// File: doc/BRIEF.md
# Block Address Translator

This unit maps a 32-bit effective address onto a physical page through a small, fully associative set of variable-length block mappings. Two independent banks of four entries are held: one consulted for instruction fetches and one for data accesses. Each entry is a pair of 32-bit words. The tag word holds the effective block base, a block-length field and two privilege-valid bits. The map word holds the physical block base and the permission bits.

A lookup is presented on the request port for one cycle. One clock later the response port shows one of three outcomes. A hit carries the physical page address and the granted read/write rights, together with a fault flag if the access needs a right that the entry does not give. A miss means the access must go on to the segment-based translator that sits beside this block. A bypass occurs when translation is switched off for the access type, and the address then passes through untouched. Entries are loaded through a simple write port. Writing a tag word trims the stored base bits that fall under the new block length, in both words of the pair.

Top module: `blk_xlate`

## Requirements
- R1: `req_fetch`=1 consults only the instruction bank (written with `cfg_fetch_set`=1); `req_fetch`=0 consults only the data bank (`cfg_fetch_set`=0).
- R2: An entry can match only if effective-address bits 31:28 equal tag-word bits 31:28 exactly.
- R3: The length field, tag-word bits 12:2, is aligned to address bits 27:17. Address bits 27:17 are compared with tag bits 27:17 only where the length field holds 0.
- R4: An entry is usable only if tag bit 1 is set for a supervisor access (`req_user`=0) or tag bit 0 is set for a user access (`req_user`=1).
- R5: On a hit, the physical address has the following fields. Bits 31:28 come from map bits 31:28. Bits 27:17 are map bits 27:17 ORed with the address bits that the length field selects. Bits 16:12 are taken from the address. Bits 11:0 are zero.
- R6: Rights come from map bits 1:0. Bit 1 set gives read and write. Only bit 0 set gives read only. Both clear gives nothing. A hit whose access (`req_write` 1 = write) lacks its right raises `rsp_fault`.
- R7: When translation is off for the access type (`xlat_ifetch_en` for fetches, `xlat_data_en` for data), the response is a hit. The address is returned with bits 11:0 cleared, read and write are granted, and no fault is raised.
- R8: A tag-word write stores the value with bits 27:17 cleared under its own length field and bits 16:13 cleared. In the companion map word it clears the same 27:17 bits, keeps bits 31:28 and 6:3 and 1:0, and zeroes the rest.
- R9: When several entries are usable, the lowest-numbered one supplies the result; its index appears on `rsp_way`.
- R10: With no usable matching entry and translation on, `rsp_miss`=1 while hit, fault, rights, way and address are all zero.
- R11: Each request cycle produces exactly one `rsp_valid` pulse on the next cycle; `rsp_valid` is low otherwise.
- R12: After reset every entry is cleared (so any translated lookup misses) and all response outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Entry write strobe |
| cfg_fetch_set | input | 1 | 1 writes the instruction bank, 0 the data bank |
| cfg_idx | input | 2 | Entry index to write |
| cfg_upper | input | 1 | 1 writes the tag word, 0 the map word |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Lookup request |
| req_ea | input | 32 | Effective address |
| req_fetch | input | 1 | 1 for instruction fetch, 0 for data |
| req_write | input | 1 | 1 for store, 0 for load or fetch |
| req_user | input | 1 | 1 for user state, 0 for supervisor |
| xlat_ifetch_en | input | 1 | Translation enable for fetches |
| xlat_data_en | input | 1 | Translation enable for data |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_hit | output | 1 | Entry hit or bypass |
| rsp_miss | output | 1 | No usable entry; hand on to segment path |
| rsp_fault | output | 1 | Hit lacking the needed permission |
| rsp_pa | output | 32 | Physical page address |
| rsp_rd_ok | output | 1 | Read permitted |
| rsp_wr_ok | output | 1 | Write permitted |
| rsp_way | output | 2 | Index of winning entry |

## Verification
The bench programs both banks and then probes the corner cases. It checks a long block whose raw tag and map words carry bits under the length field. A design that skipped the trim on tag writes would then miss the block, or leak stale map bits into the physical address. It also aims at two entries that overlap and differ only in privilege validity. Faulty priority or a swap of the privilege bits would return the wrong entry. Further checks cover a fetch that would hit only in the data bank, a read-only entry that gets a store, a no-access entry, and bypass enabled for one access type only. A design that shares banks, ignores permissions or mixes up the two enables would report the wrong outcome.

// File: rtl/bxl_pkg.sv
package bxl_pkg;
  localparam int WORD_W  = 32;
  localparam int LEN_LSB = 17;
  localparam int LEN_MSB = 27;
  localparam int LEN_W   = LEN_MSB - LEN_LSB + 1;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LEN_W-1:0]  lenmask_t;

  // length field of a tag word, aligned to address bits 27:17
  function automatic lenmask_t len_of(word_t tag);
    return tag[12:2];
  endfunction

  // tag word as stored after a write
  function automatic word_t trim_tag(word_t v);
    return {v[31:28], v[27:17] & ~len_of(v), 4'b0000, v[12:0]};
  endfunction

  // map word after its companion tag word is written
  function automatic word_t trim_map(word_t m, lenmask_t msk);
    return {m[31:28], m[27:17] & ~msk, 10'b0, m[6:3], 1'b0, m[1:0]};
  endfunction
endpackage

// File: rtl/bxl_bank.sv
module bxl_bank
  import bxl_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic                          wr_upper,
  input  word_t                         wr_data,
  output logic [ENTRIES-1:0][WORD_W-1:0] tag_q,
  output logic [ENTRIES-1:0][WORD_W-1:0] map_q
);
  logic [ENTRIES-1:0][WORD_W-1:0] tag_d, map_d;
  logic [ENTRIES-1:0]             ent_en;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_comb begin
      ent_en[i] = wr_en && (wr_idx == IDX_W'(i));
      if (wr_upper) begin
        tag_d[i] = trim_tag(wr_data);
        map_d[i] = trim_map(map_q[i], len_of(wr_data));
      end else begin
        tag_d[i] = tag_q[i];
        map_d[i] = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[i] <= '0;
        map_q[i] <= '0;
      end else if (ent_en[i]) begin
        tag_q[i] <= tag_d[i];
        map_q[i] <= map_d[i];
      end
    end

    // R8: stored tag never holds base bits under its own length field
    p_tag_trim_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_q[i][27:17] & tag_q[i][12:2]) == '0);

    // R8: map word scrubbed under the new length, permission bits kept
    p_map_trim_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_en[i] && wr_upper) |=>
        ((map_q[i][27:17] & tag_q[i][12:2]) == '0) &&
        (map_q[i][1:0] == $past(map_q[i][1:0])) &&
        (map_q[i][16:7] == '0));
  end
endmodule

// File: rtl/bxl_match.sv
module bxl_match
  import bxl_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  word_t                          ea,
  input  logic                           user,
  input  logic [ENTRIES-1:0][WORD_W-1:0] tag,
  output logic [ENTRIES-1:0]             usable
);
  logic [ENTRIES-1:0] unused_tag_bits;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic     hi_eq, mid_eq, priv_ok;
    lenmask_t msk;
    always_comb begin
      msk     = len_of(tag[i]);
      hi_eq   = (ea[31:28] == tag[i][31:28]);
      mid_eq  = ((ea[27:17] & ~msk) == tag[i][27:17]);
      priv_ok = user ? tag[i][0] : tag[i][1];
      usable[i] = hi_eq && mid_eq && priv_ok;
    end
    assign unused_tag_bits[i] = ^tag[i][16:13];
  end

  logic unused_ea;
  assign unused_ea = ^ea[16:0];
endmodule

// File: rtl/bxl_pick.sv
module bxl_pick
  import bxl_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  word_t                          ea,
  input  logic [ENTRIES-1:0]             usable,
  input  logic [ENTRIES-1:0][WORD_W-1:0] tag,
  input  logic [ENTRIES-1:0][WORD_W-1:0] map,
  output logic                           any,
  output logic [IDX_W-1:0]               way,
  output word_t                          pa,
  output logic                           rd_ok,
  output logic                           wr_ok
);
  word_t    sel_tag, sel_map;
  lenmask_t msk;

  always_comb begin
    any = 1'b0;
    way = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (usable[i]) begin
        any = 1'b1;
        way = IDX_W'(i);
      end
    end
  end

  always_comb begin
    sel_tag = tag[way];
    sel_map = map[way];
    msk     = len_of(sel_tag);
    if (any) begin
      pa    = {sel_map[31:28], (ea[27:17] & msk) | sel_map[27:17],
               ea[16:12], 12'h000};
      rd_ok = sel_map[1] | sel_map[0];
      wr_ok = sel_map[1];
    end else begin
      pa    = '0;
      rd_ok = 1'b0;
      wr_ok = 1'b0;
    end
  end

  logic unused_sel;
  assign unused_sel = ^{sel_tag[31:13], sel_tag[1:0], sel_map[16:2], ea[31:28], ea[11:0]};
endmodule

// File: rtl/blk_xlate.sv
module blk_xlate
  import bxl_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_fetch_set,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_upper,
  input  logic [31:0]      cfg_wdata,
  input  logic             req_valid,
  input  logic [31:0]      req_ea,
  input  logic             req_fetch,
  input  logic             req_write,
  input  logic             req_user,
  input  logic             xlat_ifetch_en,
  input  logic             xlat_data_en,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_fault,
  output logic [31:0]      rsp_pa,
  output logic             rsp_rd_ok,
  output logic             rsp_wr_ok,
  output logic [IDX_W-1:0] rsp_way
);
  localparam int NSETS = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  // banks: index 1 = instruction, index 0 = data
  logic [ENTRIES-1:0][WORD_W-1:0] set_tag [NSETS];
  logic [ENTRIES-1:0][WORD_W-1:0] set_map [NSETS];

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    bxl_bank #(.ENTRIES(ENTRIES)) u_bank (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .wr_en    (cfg_we && (cfg_fetch_set == s[0])),
      .wr_idx   (cfg_idx),
      .wr_upper (cfg_upper),
      .wr_data  (cfg_wdata),
      .tag_q    (set_tag[s]),
      .map_q    (set_map[s])
    );
  end

  logic [ENTRIES-1:0][WORD_W-1:0] cur_tag, cur_map;
  logic [ENTRIES-1:0]             usable;
  logic                           any;
  logic [IDX_W-1:0]               way;
  word_t                          pick_pa;
  logic                           pick_rd, pick_wr;
  logic                           bypass;

  assign cur_tag = set_tag[req_fetch];
  assign cur_map = set_map[req_fetch];
  assign bypass  = req_fetch ? !xlat_ifetch_en : !xlat_data_en;

  bxl_match #(.ENTRIES(ENTRIES)) u_match (
    .ea     (req_ea),
    .user   (req_user),
    .tag    (cur_tag),
    .usable (usable)
  );

  bxl_pick #(.ENTRIES(ENTRIES)) u_pick (
    .ea     (req_ea),
    .usable (usable),
    .tag    (cur_tag),
    .map    (cur_map),
    .any    (any),
    .way    (way),
    .pa     (pick_pa),
    .rd_ok  (pick_rd),
    .wr_ok  (pick_wr)
  );

  // next-state of the response
  logic             hit_d, miss_d, fault_d, rd_d, wr_d;
  word_t            pa_d;
  logic [IDX_W-1:0] way_d;

  always_comb begin
    hit_d = 1'b0; miss_d = 1'b0; fault_d = 1'b0;
    rd_d  = 1'b0; wr_d   = 1'b0; pa_d    = '0; way_d = '0;
    if (bypass) begin
      hit_d = 1'b1;
      rd_d  = 1'b1;
      wr_d  = 1'b1;
      pa_d  = {req_ea[31:12], 12'h000};
    end else if (any) begin
      hit_d   = 1'b1;
      rd_d    = pick_rd;
      wr_d    = pick_wr;
      pa_d    = pick_pa;
      way_d   = way;
      fault_d = req_write ? !pick_wr : !pick_rd;
    end else begin
      miss_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rsp_valid <= 1'b0;
    else            rsp_valid <= req_valid;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_rd_ok <= 1'b0;
      rsp_wr_ok <= 1'b0;
      rsp_pa    <= '0;
      rsp_way   <= '0;
    end else if (req_valid) begin
      rsp_hit   <= hit_d;
      rsp_miss  <= miss_d;
      rsp_fault <= fault_d;
      rsp_rd_ok <= rd_d;
      rsp_wr_ok <= wr_d;
      rsp_pa    <= pa_d;
      rsp_way   <= way_d;
    end
  end

  // R11: one response strobe per request, one cycle later
  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid |=> rsp_valid);
  p_no_spur_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    !req_valid |=> !rsp_valid);

  // R10: exactly one of hit/miss, and a miss carries nothing
  p_outcome_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_valid |-> $onehot({rsp_hit, rsp_miss}));
  p_miss_quiet_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rsp_valid && rsp_miss) |-> (!rsp_rd_ok && !rsp_wr_ok && !rsp_fault && rsp_pa == '0));

  // R6: write right implies read right; fault matches the access kind
  p_rw_rd_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rsp_valid && rsp_wr_ok) |-> rsp_rd_ok);
  p_fault_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && !bypass && any) |=>
      (rsp_fault == ($past(req_write) ? !rsp_wr_ok : !rsp_rd_ok)));

  // R7: bypass returns the page of the effective address with full rights
  p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && bypass) |=>
      (rsp_hit && rsp_rd_ok && rsp_wr_ok && !rsp_fault &&
       rsp_pa == {$past(req_ea[31:12]), 12'h000}));

  // R5: page offset never leaks into the physical address
  p_pa_low_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_valid |-> (rsp_pa[11:0] == 12'h000));

  // R9: winner is usable and no lower entry is usable
  p_lowest_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    any |-> (usable[way] &&
             ((usable & ((ENTRIES'(1) << way) - ENTRIES'(1))) == '0)));

  logic unused_ea;
  assign unused_ea = ^req_ea[11:0];
endmodule

// File: tb/blk_xlate_tb_top.sv
module blk_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_fetch_set, cfg_upper;
  logic [1:0]  cfg_idx;
  logic [31:0] cfg_wdata;
  logic        req_valid, req_fetch, req_write, req_user;
  logic [31:0] req_ea;
  logic        xlat_ifetch_en, xlat_data_en;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_rd_ok, rsp_wr_ok;
  logic [31:0] rsp_pa;
  logic [1:0]  rsp_way;

  int checks = 0;
  int errors = 0;
  logic [38:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  blk_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_fetch_set(cfg_fetch_set),
    .cfg_idx(cfg_idx), .cfg_upper(cfg_upper), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ea(req_ea), .req_fetch(req_fetch),
    .req_write(req_write), .req_user(req_user),
    .xlat_ifetch_en(xlat_ifetch_en), .xlat_data_en(xlat_data_en),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_fault(rsp_fault), .rsp_pa(rsp_pa), .rsp_rd_ok(rsp_rd_ok),
    .rsp_wr_ok(rsp_wr_ok), .rsp_way(rsp_way)
  );

  task automatic check(input bit ok, input string req, input logic [38:0] act,
                       input logic [38:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected items as responses appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      logic [38:0] act;
      act = {rsp_hit, rsp_miss, rsp_fault, rsp_rd_ok, rsp_wr_ok, rsp_way, rsp_pa};
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected response", act, '0);
      end else begin
        logic [38:0] e;
        string       t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(act == e, t, act, e);
      end
    end
  end

  task automatic wr(input bit iset, input int idx, input bit upper, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_fetch_set = iset; cfg_idx = 2'(idx);
    cfg_upper = upper; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // driver: issues a lookup and pushes its expected response
  task automatic look(input logic [31:0] ea, input bit fetch, input bit write,
                      input bit user, input bit hit, input bit miss, input bit fault,
                      input bit rd, input bit wrok, input int way,
                      input logic [31:0] pa, input string t);
    @(negedge clk);
    req_valid = 1'b1; req_ea = ea; req_fetch = fetch;
    req_write = write; req_user = user;
    exp_q.push_back({hit, miss, fault, rd, wrok, 2'(way), pa});
    tag_q.push_back(t);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", '0, '1);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none
  end

  initial begin
    rst_n = 1'b0;
    cfg_we = 0; cfg_fetch_set = 0; cfg_idx = 0; cfg_upper = 0; cfg_wdata = 0;
    req_valid = 0; req_ea = 0; req_fetch = 0; req_write = 0; req_user = 0;
    xlat_ifetch_en = 1; xlat_data_en = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12: outputs low after reset, cleared entries miss
    check({rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_rd_ok, rsp_wr_ok} == 6'b0,
          "R12 reset outputs", 39'({rsp_valid, rsp_hit, rsp_miss}), '0);
    look(32'h8001_2345, 0, 0, 0, 0, 1, 0, 0, 0, 0, 32'h0, "R12 empty bank misses");

    // program data bank (cfg_fetch_set=0) and instruction bank (=1)
    wr(0, 0, 0, 32'h1000_0002); wr(0, 0, 1, 32'h8000_0002);
    wr(0, 1, 0, 32'h300E_0001); wr(0, 1, 1, 32'h900E_001D);
    wr(0, 2, 0, 32'h5000_0000); wr(0, 2, 1, 32'hA000_0003);
    wr(0, 3, 0, 32'h7000_0002); wr(0, 3, 1, 32'h8000_0003);
    wr(1, 0, 0, 32'h2000_0001); wr(1, 0, 1, 32'h8000_0002);

    look(32'h8001_2345, 0, 0, 0, 1, 0, 0, 1, 1, 0, 32'h1001_2000, "R5 short block translate");
    look(32'h8001_2345, 0, 0, 1, 1, 0, 0, 1, 1, 3, 32'h7001_2000, "R9 R4 user falls to entry 3");
    look(32'h8002_0000, 0, 0, 0, 0, 1, 0, 0, 0, 0, 32'h0, "R3 bit outside short block");
    look(32'h900A_5678, 0, 0, 0, 0, 1, 0, 0, 0, 0, 32'h0, "R4 supervisor not valid");
    look(32'h900A_5678, 0, 0, 1, 1, 0, 0, 1, 0, 1, 32'h300A_5000, "R8 R3 long block trimmed");
    look(32'h900A_5678, 0, 1, 1, 1, 0, 1, 1, 0, 1, 32'h300A_5000, "R6 store to read-only");
    look(32'h9010_0000, 0, 0, 1, 0, 1, 0, 0, 0, 0, 32'h0, "R3 bit above long block");
    look(32'hA000_1000, 0, 0, 0, 1, 0, 1, 0, 0, 2, 32'h5000_1000, "R6 no-access entry");
    look(32'h8001_2345, 0, 1, 0, 1, 0, 0, 1, 1, 0, 32'h1001_2000, "R6 store to read-write");
    look(32'h8001_2345, 1, 0, 0, 1, 0, 0, 1, 0, 0, 32'h2001_2000, "R1 fetch uses instr bank");
    look(32'h8001_2345, 1, 0, 1, 0, 1, 0, 0, 0, 0, 32'h0, "R1 R4 fetch user invalid");
    look(32'h900A_5678, 1, 0, 1, 0, 1, 0, 0, 0, 0, 32'h0, "R1 data-only block misses on fetch");
    look(32'h0001_2345, 0, 0, 0, 0, 1, 0, 0, 0, 0, 32'h0, "R2 top nibble mismatch");

    @(negedge clk); xlat_data_en = 0;
    look(32'h1234_5678, 0, 1, 1, 1, 0, 0, 1, 1, 0, 32'h1234_5000, "R7 data bypass");
    look(32'h8001_2345, 1, 0, 0, 1, 0, 0, 1, 0, 0, 32'h2001_2000, "R7 fetch still translated");
    @(negedge clk); xlat_data_en = 1; xlat_ifetch_en = 0;
    look(32'hFFFF_FFFF, 1, 0, 1, 1, 0, 0, 1, 1, 0, 32'hFFFF_F000, "R7 fetch bypass");
    look(32'h900A_5678, 0, 0, 1, 1, 0, 0, 1, 0, 1, 32'h300A_5000, "R7 data still translated");
    @(negedge clk); xlat_ifetch_en = 1;

    // R8: retag entry 0 with a longer block; stale map bit 17 must be cleared
    wr(0, 0, 0, 32'h1FFE_0002); wr(0, 0, 1, 32'h8000_0006);
    look(32'h8000_3000, 0, 0, 0, 1, 0, 0, 1, 1, 0, 32'h1FFC_3000, "R8 map scrubbed on retag");
    look(32'h8002_3000, 0, 0, 0, 1, 0, 0, 1, 1, 0, 32'h1FFE_3000, "R5 masked bit from address");

    repeat (3) @(negedge clk);
    // R11: idle cycles produce no response and every item was answered
    check(rsp_valid == 1'b0, "R11 idle no strobe", 39'(rsp_valid), '0);
    check(exp_q.size() == 0, "R11 all responses seen", 39'(exp_q.size()), '0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule